// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block sits between a 16-bit-bus processor and its local memory and I/O. It takes a 24-bit byte address, given as a word address plus two byte-lane enables, and steers each access to a boot ROM, to main RAM, or to one of eight peripheral select lines. The ROM and the RAM are small behavioural arrays held inside the block. The peripherals themselves are external. The block only decodes their selects.

A reset sets an overlay flag. While the flag is set, every read in the memory window returns boot ROM data, so the processor fetches its reset vectors and early code from ROM even though it starts at address zero. The first read or write at or above the ROM home base clears the flag on the clock edge that ends that access. From then on, low memory reads return RAM. Writes to the RAM range reach RAM at all times, so boot code can fill RAM while the overlay is still in place.

Top module: `bootovl_decoder`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets the overlay flag, and only a reset sets it again. While the flag is set, a read at any byte address below 0xFF0000 returns the ROM word selected by byte address bits [12:1].
- R2: A read or write at byte address 0xFE0000 or above clears the flag on the rising edge that ends the access. That access is still decoded with the flag set, and from the next cycle a read below 0x080000 returns RAM.
- R3: With the flag clear, reads and writes at byte addresses 0x000000 to 0x07FFFF reach RAM. The RAM holds RAM_WORDS 16-bit words (1024 by default) and is mirrored across the range by word address modulo RAM_WORDS. A write updates only the lanes whose enable is set: be[1] covers rdata/wdata[15:8] (even byte), be[0] covers [7:0] (odd byte).
- R4: A write below 0x080000 raises ram_we equal to be in that cycle and stores the data, even while the flag is set.
- R5: A write at 0x080000 or above leaves ram_we at 0 and changes no RAM or ROM content.
- R6: With the flag clear, a read at 0x080000 to 0xFDFFFF, or at 0xFF0000 and above, returns 0xFFFF.
- R7: Byte address range 0xFE0000 to 0xFEFFFF always reads ROM, mirrored every 8 KB. For word index i = byte address bits [12:1], the even byte (rdata[15:8]) is i[7:0] XOR i[11:8] XOR 0x5A, and the odd byte (rdata[7:0]) is (i[7:0] + 16*i[11:8] + 0x11) mod 256.
- R8: For a read or write with be[0] set and byte address bits [23:8] equal to 0xFFC0, the block decodes bits [7:4] as follows:
  - 0 drives periph_sel bit 0 (timer A).
  - 2 drives bit 1 (configuration/floppy parallel port).
  - 3 drives bit 2 (serial B).
  - 4 drives bit 3 (interrupt controller).
  - 5 drives bit 4 (floppy controller).
  - 6 drives bit 5 (printer parallel port).
  - 7 drives bit 6 (serial A).
  - 1, and any address outside that page, drives no select.
- R9: Timer B (periph_sel bit 7) responds to every byte address from 0xFFC080 to 0xFFC0FF, ignoring bits [6:3].
- R10: With be[0] low, no peripheral select is driven.
- R11: At most one periph_sel bit is high in any cycle, and none is high when rd and wr are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay flag |
| addr | input | 23 | Word address, byte address bits [23:1] |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| be | input | 2 | Byte-lane enables: [1] even byte / data[15:8], [0] odd byte / data[7:0] |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of a read |
| ram_we | output | 2 | Per-lane RAM write enable |
| periph_sel | output | 8 | One-hot peripheral selects |

## Verification
The same low addresses are read three times: during the overlay, after writes made under the overlay, and after the first ROM-home access. Only the flag timing can explain the different results across those three reads. Reads at 0x002004 and 0xFE2000 use addresses that differ from a small index only in higher bits. They tell ROM mirroring on bits [12:1] apart from a wider decode, and a RAM read at 0x000810 does the same for RAM aliasing. Peripheral cycles walk every slot, the unused slot, the timer B mirror, a high-lane-only access and an idle cycle, so a wrong slot code, a missing lane gate or a missing strobe gate each shows up as a different select pattern. A second reset in mid-run shows that the overlay returns while RAM contents survive.

// File: rtl/bootovl_pkg.sv
package bootovl_pkg;

   localparam int LANES       = 2;
   localparam int NUM_SEL     = 8;
   localparam int FIXED_SLOTS = 7;

   typedef enum int {
      SEL_TMR_A  = 0,
      SEL_CFGPIO = 1,
      SEL_SER_B  = 2,
      SEL_IRQC   = 3,
      SEL_FDC    = 4,
      SEL_PRNPIO = 5,
      SEL_SER_A  = 6,
      SEL_TMR_B  = 7
   } sel_idx_e;

   // address bits [7:4] of each fixed 16-byte slot, indexed like sel_idx_e
   localparam logic [3:0] SLOT_CODE [FIXED_SLOTS] = '{
      4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7
   };

endpackage

// File: rtl/bootovl_rom_lane.sv
module bootovl_rom_lane #(
   parameter int IDX_W = 12,
   parameter bit EVEN  = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       q
);
   logic [15:0] wide;
   assign wide = 16'(idx);

   if (IDX_W < 2 || IDX_W > 15) begin : g_bad_idx
      $error("bootovl_rom_lane: IDX_W out of range");
   end

   if (EVEN) begin : g_even
      assign q = wide[7:0] ^ wide[15:8] ^ 8'h5A;
   end else begin : g_odd
      assign q = wide[7:0] + (wide[15:8] << 4) + 8'h11;
   end
endmodule

// File: rtl/bootovl_ram_bank.sv
module bootovl_ram_bank #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] idx,
   input  logic [7:0]    d,
   output logic [7:0]    q
);
   localparam int DEPTH = 2 ** AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= d;
   end

   assign q = mem[idx];
endmodule

// File: rtl/bootovl_periph_dec.sv
module bootovl_periph_dec
   import bootovl_pkg::*;
#(
   parameter int              PAGE_W = 16,
   parameter logic [PAGE_W-1:0] PAGE = 16'hFFC0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               access,
   input  logic               lane_lo,
   input  logic [PAGE_W-1:0]  page,
   input  logic [3:0]         slot,
   output logic [NUM_SEL-1:0] sel
);
   logic active;
   assign active = access && lane_lo && (page == PAGE);

   for (genvar s = 0; s < FIXED_SLOTS; s++) begin : g_slot
      assign sel[s] = active && (slot == SLOT_CODE[s]);
   end

   // timer B: upper half of the page, bits [6:3] don't care
   assign sel[SEL_TMR_B] = active && slot[3];

   // R11
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R11
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !access |-> (sel == '0));

   // R10
   sel_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_lo |-> (sel == '0));
endmodule

// File: rtl/bootovl_decoder.sv
module bootovl_decoder
   import bootovl_pkg::*;
#(
   parameter int                ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] RAM_TOP     = 24'h080000,
   parameter logic [ADDR_W-1:0] ROM_HOME    = 24'hFE0000,
   parameter logic [ADDR_W-1:0] MEM_END     = 24'hFF0000,
   parameter logic [ADDR_W-1:0] PERIPH_BASE = 24'hFFC000,
   parameter int                ROM_BYTES   = 8192,
   parameter int                RAM_WORDS   = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:1]   addr,
   input  logic                rd,
   input  logic                wr,
   input  logic [LANES-1:0]    be,
   input  logic [8*LANES-1:0]  wdata,
   output logic [8*LANES-1:0]  rdata,
   output logic [LANES-1:0]    ram_we,
   output logic [NUM_SEL-1:0]  periph_sel
);
   localparam int ROM_AW = $clog2(ROM_BYTES);
   localparam int RAM_AW = $clog2(RAM_WORDS);
   localparam int PAGE_W = ADDR_W - 8;

   // elaboration-time parameter checks
   if ((1 << ROM_AW) != ROM_BYTES || ROM_AW < 3 || ROM_AW > 16) begin : g_bad_rom
      $error("bootovl_decoder: ROM_BYTES must be a power of two, 8..65536");
   end
   if ((1 << RAM_AW) != RAM_WORDS || RAM_AW < 1) begin : g_bad_ram
      $error("bootovl_decoder: RAM_WORDS must be a power of two");
   end
   if (RAM_TOP > ROM_HOME || ROM_HOME >= MEM_END || MEM_END > PERIPH_BASE) begin : g_bad_map
      $error("bootovl_decoder: region bases out of order");
   end

   logic [ADDR_W-1:0] byte_addr;
   logic              access, in_ram, in_mem, at_home, above_home;
   logic              overlay_q;

   assign byte_addr  = {addr, 1'b0};
   assign access     = rd || wr;
   assign in_ram     = byte_addr < RAM_TOP;
   assign in_mem     = byte_addr < MEM_END;
   assign above_home = byte_addr >= ROM_HOME;
   assign at_home    = above_home && in_mem;

   // overlay flag: set by reset, dropped by first access at/above ROM home
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     overlay_q <= 1'b1;
      else if (access && above_home)  overlay_q <= 1'b0;
   end

   assign ram_we = (wr && in_ram) ? be : '0;

   logic [8*LANES-1:0] rom_word, ram_word;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      bootovl_rom_lane #(
         .IDX_W (ROM_AW - 1),
         .EVEN  (l == LANES - 1)
      ) u_rom (
         .idx (addr[ROM_AW-1:1]),
         .q   (rom_word[8*l +: 8])
      );

      bootovl_ram_bank #(
         .AW (RAM_AW)
      ) u_ram (
         .clk (clk),
         .we  (ram_we[l]),
         .idx (addr[RAM_AW:1]),
         .d   (wdata[8*l +: 8]),
         .q   (ram_word[8*l +: 8])
      );
   end

   always_comb begin
      if (in_mem && (overlay_q || at_home)) rdata = rom_word;
      else if (in_ram)                      rdata = ram_word;
      else                                  rdata = '1;
   end

   bootovl_periph_dec #(
      .PAGE_W (PAGE_W),
      .PAGE   (PERIPH_BASE[ADDR_W-1:8])
   ) u_pdec (
      .clk     (clk),
      .rst_n   (rst_n),
      .access  (access),
      .lane_lo (be[0]),
      .page    (byte_addr[ADDR_W-1:8]),
      .slot    (byte_addr[7:4]),
      .sel     (periph_sel)
   );

   // R2
   overlay_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overlay_q && access && above_home) |=> !overlay_q);

   // R1
   overlay_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !overlay_q |=> !overlay_q);

   // R5
   no_stray_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || !in_ram) |-> (ram_we == '0));

   // R4
   low_write_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && in_ram) |-> (ram_we == be));
endmodule

// File: tb/bootovl_decoder_tb.sv
`timescale 1ns/1ps
module bootovl_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:1] addr = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [1:0]  be = 2'b00;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  ram_we;
   logic [7:0]  periph_sel;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   bit ovl = 1;
   logic [7:0] m_hi [int];
   logic [7:0] m_lo [int];

   always #2.5 clk = ~clk;

   bootovl_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .be(be),
      .wdata(wdata), .rdata(rdata), .ram_we(ram_we), .periph_sel(periph_sel)
   );

   function automatic logic [15:0] rom_ref(logic [23:0] a);
      logic [7:0] lo8, hi8, ev, od;
      lo8 = a[8:1];
      hi8 = {4'h0, a[12:9]};
      ev  = lo8 ^ hi8 ^ 8'h5A;
      od  = lo8 + (hi8 * 8'd16) + 8'h11;
      return {ev, od};
   endfunction

   function automatic logic [15:0] exp_read(logic [23:0] a);
      int k;
      if (a < 24'hFF0000 && (ovl || a >= 24'hFE0000)) return rom_ref(a);
      if (a < 24'h080000) begin
         k = (a >> 1) % 1024;
         if (!m_hi.exists(k) || !m_lo.exists(k)) return 16'hxxxx;
         return {m_hi[k], m_lo[k]};
      end
      return 16'hFFFF;
   endfunction

   function automatic logic [7:0] exp_sel(logic [23:0] a, bit r, bit w, logic [1:0] b);
      if (!(r || w) || !b[0] || a[23:8] != 16'hFFC0) return 8'h00;
      case (a[7:4])
         4'h0: return 8'h01;
         4'h2: return 8'h02;
         4'h3: return 8'h04;
         4'h4: return 8'h08;
         4'h5: return 8'h10;
         4'h6: return 8'h20;
         4'h7: return 8'h40;
         4'h1: return 8'h00;
         default: return 8'h80;
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(string tag, logic [23:0] a, bit r, bit w, logic [1:0] b, logic [15:0] d);
      int k;
      @(negedge clk);
      addr = a[23:1]; rd = r; wr = w; be = b; wdata = d;
      #1;
      if (r) chk(tag, "rdata", rdata, exp_read(a));
      chk(tag, "ram_we", {14'b0, ram_we}, (w && a < 24'h080000) ? {14'b0, b} : 16'h0);
      chk(tag, "periph_sel", {8'b0, periph_sel}, {8'b0, exp_sel(a, r, w, b)});
      @(posedge clk);
      if (w && a < 24'h080000) begin
         k = (a >> 1) % 1024;
         if (b[1]) m_hi[k] = d[15:8];
         if (b[0]) m_lo[k] = d[7:0];
      end
      if ((r || w) && a >= 24'hFE0000) ovl = 0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // reset state (R1, R11)
      repeat (2) @(negedge clk);
      addr = '0; rd = 1'b1;
      #1;
      chk("R1", "rdata in reset", rdata, rom_ref(24'h000000));
      chk("R11", "sel in reset", {8'b0, periph_sel}, 16'h0);
      rd = 1'b0;
      @(negedge clk) rst_n = 1'b1;

      // overlay reads (R1, R7)
      cyc("R1", 24'h000000, 1, 0, 2'b11, 0);
      cyc("R1", 24'h000002, 1, 0, 2'b11, 0);
      cyc("R7", 24'h001FFE, 1, 0, 2'b11, 0);
      cyc("R7", 24'h002004, 1, 0, 2'b11, 0);
      cyc("R1", 24'h07FFF0, 1, 0, 2'b11, 0);
      cyc("R1", 24'h123456, 1, 0, 2'b11, 0);

      // writes under the overlay (R4, R5)
      cyc("R4", 24'h000010, 0, 1, 2'b11, 16'hBEEF);
      cyc("R1", 24'h000010, 1, 0, 2'b11, 0);
      cyc("R4", 24'h000020, 0, 1, 2'b11, 16'h1111);
      cyc("R4", 24'h000020, 0, 1, 2'b01, 16'h22AA);
      cyc("R4", 24'h000000, 0, 1, 2'b11, 16'h1234);
      cyc("R5", 24'h100000, 0, 1, 2'b11, 16'hDEAD);
      cyc("R5", 24'h000800 + 24'h080000, 0, 1, 2'b11, 16'hDEAD);

      // first ROM-home access drops overlay (R2)
      cyc("R2", 24'hFE0004, 1, 0, 2'b11, 0);
      cyc("R2", 24'h000010, 1, 0, 2'b11, 0);

      // RAM behaviour (R3, R5)
      cyc("R3", 24'h000020, 1, 0, 2'b11, 0);
      cyc("R3", 24'h000810, 1, 0, 2'b11, 0);
      cyc("R5", 24'h000000, 1, 0, 2'b11, 0);
      cyc("R3", 24'h07FFFE, 0, 1, 2'b11, 16'hCAFE);
      cyc("R3", 24'h07FFFE, 1, 0, 2'b11, 0);
      cyc("R3", 24'h000020, 0, 1, 2'b10, 16'h77FF);
      cyc("R3", 24'h000020, 1, 0, 2'b11, 0);

      // unmapped reads (R6), ROM home and mirror (R7)
      cyc("R6", 24'h080000, 1, 0, 2'b11, 0);
      cyc("R6", 24'h500000, 1, 0, 2'b11, 0);
      cyc("R6", 24'hFDFFFE, 1, 0, 2'b11, 0);
      cyc("R6", 24'hFFC030, 1, 0, 2'b11, 0);
      cyc("R7", 24'hFE2000, 1, 0, 2'b11, 0);
      cyc("R7", 24'hFEFFFE, 1, 0, 2'b11, 0);
      cyc("R5", 24'hFE0010, 0, 1, 2'b11, 16'h0000);
      cyc("R5", 24'hFE0010, 1, 0, 2'b11, 0);

      // peripheral selects (R8, R9, R10, R11)
      cyc("R8", 24'hFFC001, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFC011, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFC021, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFC031, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFC041, 0, 1, 2'b01, 16'h0055);
      cyc("R8", 24'hFFC051, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFC061, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFC071, 0, 1, 2'b01, 16'h0041);
      cyc("R9", 24'hFFC081, 1, 0, 2'b01, 0);
      cyc("R9", 24'hFFC0C5, 1, 0, 2'b01, 0);
      cyc("R9", 24'hFFC0FF, 0, 1, 2'b01, 16'h0001);
      cyc("R8", 24'hFFC101, 1, 0, 2'b01, 0);
      cyc("R8", 24'hFFD031, 1, 0, 2'b01, 0);
      cyc("R10", 24'hFFC031, 1, 0, 2'b10, 0);
      cyc("R10", 24'hFFC081, 0, 1, 2'b00, 16'h0000);
      cyc("R11", 24'hFFC031, 0, 0, 2'b01, 0);
      cyc("R11", 24'hFFC089, 0, 0, 2'b11, 0);

      // a fresh reset brings the overlay back; RAM keeps its data (R1, R2)
      @(negedge clk); rd = 1'b0; wr = 1'b0; rst_n = 1'b0; ovl = 1;
      @(negedge clk); rst_n = 1'b1;
      cyc("R1", 24'h000010, 1, 0, 2'b11, 0);
      cyc("R2", 24'hFFC071, 1, 0, 2'b01, 0);
      cyc("R2", 24'h000010, 1, 0, 2'b11, 0);

      @(negedge clk); rd = 1'b0; wr = 1'b0;
      done = 1;
      summary();
      $finish;
   end
endmodule